// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer with a register interface. A down-counter runs in a slow clock domain, nominally 32768 Hz. When the count reaches a programmable threshold, the block raises an early-warning interrupt. When the count reaches zero, it raises a reset request. Software keeps the system alive by writing the load-low register again before either event fires. That write reloads the counter from the stored timeout value.

Every register except the lock register is protected. Writes to them are accepted only after a magic key has been written to the lock register. The 32-bit timeout and threshold values each take two registers, a low half and a high half. They move into the slow domain through a toggle handshake. While that transfer is in flight, a busy flag is visible and the load registers cannot be changed. The count is carried back to the bus domain as a snapshot through a second handshake, so its two halves always belong to the same sample.

Top module: `kwd_top`

## Requirements
- R1: After reset the block is locked. Writing exactly 0x0000E551 to the lock register (0x20) unlocks it. Writing any other value to that register locks it. Bit 0 of the lock register reads 1 while the block is unlocked.
- R2: While the block is locked, writes to every register other than the lock register have no effect on the stored values.
- R3: The timeout load value is split across two registers: load-low (0x00) holds bits 15:0 and load-high (0x04) holds bits 31:16. The threshold value is split the same way: threshold-low (0x2C) and threshold-high (0x30). Each register keeps only bits 15:0 of the write data, and its bits 31:16 read back as 0.
- R4: The control register (0x08) keeps write data bits 3:0 and reads them back. Bit 0 enables the interrupt, bit 1 enables the counter, bit 2 is a stored mode bit, and bit 3 enables the reset request.
- R5: A write to load-low starts a transfer of the load and threshold values into the slow domain. Raw-status bit 4 (0x10) reads 1 from the next cycle until the slow domain has acknowledged the transfer. While that bit is 1, writes to the four load and threshold registers are ignored.
- R6: When the transfer completes, the counter takes the load value. While control bit 1 is set, it then decrements once per slow clock cycle. It holds its value while control bit 1 is clear, and it stays at zero once it gets there.
- R7: When a decrement makes the count equal to the threshold, raw bit 0 becomes 1. It stays 1 until software writes 1 to bit 0 of the clear register (0x0C).
- R8: When a decrement makes the count reach zero, raw bit 3 becomes 1. It stays 1 until software writes 1 to bit 3 of the clear register.
- R9: The `irq` output is 1 exactly when raw bit 0, control bit 0 and the inverse of mask bit 0 (mask register 0x14) are all 1.
- R10: The `rst_req` output is 1 exactly when raw bit 3 and control bit 3 are both 1.
- R11: Count-low (0x18) and count-high (0x1C) return bits 15:0 and bits 31:16 of the same count sample. While the counter is stopped, they settle to the exact count within a few slow cycles.

Expected values used by the bench: raw bit 0 = early-warning flag, raw bit 3 = reset flag, raw bit 4 = busy, and the register offsets given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | Slow counting clock |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | Reset request |

## Verification
The bench targets these failure modes:
- A key compare that checks only some of the bits, or that does not relock on a wrong value, makes the lock readback wrong.
- A lock that fails to guard a register lets a locked write show up in readback.
- A busy window that is too short, or load registers that accept writes during busy, leave the wrong half-values in readback and the wrong count.
- Split-register sweeps with junk in the upper data bits catch swapped or leaking halves.
- A counter that wraps below zero, or that fires the threshold event on load rather than on a decrement, gives a non-zero count after the timeout or leaves a cleared flag set again.
- A four-way sweep over interrupt enable and mask, and over reset enable, catches a wrong output gate. Clearing one flag while the other is set shows whether the clears are independent.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_LOAD_LO = 6'h00;
    localparam logic [ADDR_W-1:0] A_LOAD_HI = 6'h04;
    localparam logic [ADDR_W-1:0] A_CTRL    = 6'h08;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 6'h0C;
    localparam logic [ADDR_W-1:0] A_RAW     = 6'h10;
    localparam logic [ADDR_W-1:0] A_MASK    = 6'h14;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 6'h18;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 6'h1C;
    localparam logic [ADDR_W-1:0] A_LOCK    = 6'h20;
    localparam logic [ADDR_W-1:0] A_THR_LO  = 6'h2C;
    localparam logic [ADDR_W-1:0] A_THR_HI  = 6'h30;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_E551;

    localparam int B_IRQ_EN  = 0;
    localparam int B_CNT_EN  = 1;
    localparam int B_RST_EN  = 3;
    localparam int B_FLAG_IN = 0;
    localparam int B_FLAG_RS = 3;
    localparam int B_BUSY    = 4;
endpackage

// File: rtl/kwd_sync.sv
module kwd_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d        = q;
        d.stage1 = async_in;
        d.stage2 = q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_out = q.stage2;
endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
    parameter int CNT_W = 32
) (
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             req_s,
    input  logic             en_s,
    input  logic             snap_ack_s,
    input  logic [CNT_W-1:0] load_in,
    input  logic [CNT_W-1:0] thr_in,
    output logic             ld_ack,
    output logic             warn_evt,
    output logic             rst_evt,
    output logic             snap_tgl,
    output logic [CNT_W-1:0] snap_val
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] thr;
        logic             ld_seen;
        logic             warn_tgl;
        logic             rst_tgl;
        logic [CNT_W-1:0] snap;
        logic             snap_tgl;
    } cnt_t;

    cnt_t d, q;
    logic ld_hit;
    logic [CNT_W-1:0] dec;

    assign ld_hit = (req_s != q.ld_seen);
    assign dec    = q.count - 1'b1;

    always_comb begin
        d = q;
        if (ld_hit) begin
            d.count   = load_in;
            d.thr     = thr_in;
            d.ld_seen = req_s;
        end else if (en_s && (q.count != '0)) begin
            d.count = dec;
            if (dec == q.thr) d.warn_tgl = ~q.warn_tgl;
            if (dec == '0)    d.rst_tgl  = ~q.rst_tgl;
        end
        if (snap_ack_s == q.snap_tgl) begin
            d.snap     = q.count;
            d.snap_tgl = ~q.snap_tgl;
        end
    end

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ld_ack   = q.ld_seen;
    assign warn_evt = q.warn_tgl;
    assign rst_evt  = q.rst_tgl;
    assign snap_tgl = q.snap_tgl;
    assign snap_val = q.snap;

    // R6: one step down per enabled slow cycle
    p_count_step_r6: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (!ld_hit && en_s && q.count != '0) |=> (q.count == $past(q.count) - 1'b1));

    // R6: zero is terminal until a reload
    p_no_wrap_r6: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (!ld_hit && q.count == '0) |=> (q.count == '0));

    // R11: snapshot data stays put while the bus side has not acknowledged it
    p_snap_hold_r11: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (snap_ack_s != q.snap_tgl) |=> $stable(q.snap));
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ld_ack_s,
    input  logic              warn_s,
    input  logic              rst_s,
    input  logic              snap_tgl_s,
    input  logic [CNT_W-1:0]  snap_val,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  thr_val,
    output logic              ld_req,
    output logic              cnt_en,
    output logic              snap_ack,
    output logic              irq,
    output logic              rst_req
);
    localparam int HALF = CNT_W / 2;
    localparam int UPW  = CNT_W - HALF;

    typedef struct packed {
        logic              unlocked;
        logic [3:0]        ctrl;
        logic              mask;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  thr;
        logic              ld_req;
        logic              warn_raw;
        logic              rst_raw;
        logic              warn_seen;
        logic              rst_seen;
        logic              snap_ack;
        logic [CNT_W-1:0]  cnt_cap;
        logic [DATA_W-1:0] rdata;
    } reg_t;

    reg_t d, q;
    logic busy, wr, wr_ok, rd;

    assign busy  = (q.ld_req != ld_ack_s);
    assign wr    = bus_valid && bus_write;
    assign rd    = bus_valid && !bus_write;
    assign wr_ok = wr && q.unlocked && (bus_addr != A_LOCK);

    always_comb begin
        d = q;
        if (wr && bus_addr == A_LOCK)
            d.unlocked = (bus_wdata == UNLOCK_KEY);
        if (wr_ok) begin
            case (bus_addr)
                A_CTRL:  d.ctrl = bus_wdata[3:0];
                A_MASK:  d.mask = bus_wdata[0];
                A_CLEAR: begin
                    if (bus_wdata[B_FLAG_IN]) d.warn_raw = 1'b0;
                    if (bus_wdata[B_FLAG_RS]) d.rst_raw  = 1'b0;
                end
                A_LOAD_LO: if (!busy) begin
                    d.load[HALF-1:0] = bus_wdata[HALF-1:0];
                    d.ld_req         = ~q.ld_req;
                end
                A_LOAD_HI: if (!busy) d.load[CNT_W-1:HALF] = bus_wdata[UPW-1:0];
                A_THR_LO:  if (!busy) d.thr[HALF-1:0]      = bus_wdata[HALF-1:0];
                A_THR_HI:  if (!busy) d.thr[CNT_W-1:HALF]  = bus_wdata[UPW-1:0];
                default: ;
            endcase
        end
        if (warn_s != q.warn_seen) begin
            d.warn_raw  = 1'b1;
            d.warn_seen = warn_s;
        end
        if (rst_s != q.rst_seen) begin
            d.rst_raw  = 1'b1;
            d.rst_seen = rst_s;
        end
        if (snap_tgl_s != q.snap_ack) begin
            d.cnt_cap  = snap_val;
            d.snap_ack = snap_tgl_s;
        end
        if (rd) begin
            case (bus_addr)
                A_LOAD_LO: d.rdata = {{(DATA_W-HALF){1'b0}}, q.load[HALF-1:0]};
                A_LOAD_HI: d.rdata = {{(DATA_W-UPW){1'b0}}, q.load[CNT_W-1:HALF]};
                A_THR_LO:  d.rdata = {{(DATA_W-HALF){1'b0}}, q.thr[HALF-1:0]};
                A_THR_HI:  d.rdata = {{(DATA_W-UPW){1'b0}}, q.thr[CNT_W-1:HALF]};
                A_CNT_LO:  d.rdata = {{(DATA_W-HALF){1'b0}}, q.cnt_cap[HALF-1:0]};
                A_CNT_HI:  d.rdata = {{(DATA_W-UPW){1'b0}}, q.cnt_cap[CNT_W-1:HALF]};
                A_CTRL:    d.rdata = {{(DATA_W-4){1'b0}}, q.ctrl};
                A_MASK:    d.rdata = {{(DATA_W-1){1'b0}}, q.mask};
                A_LOCK:    d.rdata = {{(DATA_W-1){1'b0}}, q.unlocked};
                A_RAW:     d.rdata = {{(DATA_W-5){1'b0}}, busy, q.rst_raw, 2'b00, q.warn_raw};
                default:   d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign load_val  = q.load;
    assign thr_val   = q.thr;
    assign ld_req    = q.ld_req;
    assign cnt_en    = q.ctrl[B_CNT_EN];
    assign snap_ack  = q.snap_ack;
    assign irq       = q.warn_raw && q.ctrl[B_IRQ_EN] && !q.mask;
    assign rst_req   = q.rst_raw && q.ctrl[B_RST_EN];

    // R2: locked writes leave the control register untouched
    p_lock_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_CTRL && !q.unlocked) |=> $stable(q.ctrl));

    // R5: starting a transfer makes busy visible on the next cycle
    p_busy_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && q.unlocked && bus_addr == A_LOAD_LO && !busy) |=> busy);

    // R5: load value is frozen while a transfer is in flight
    p_load_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(q.load[HALF-1:0]) || !$past(busy));

    // R7: warning flag is sticky until explicitly cleared
    p_warn_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.warn_raw && !(wr_ok && bus_addr == A_CLEAR && bus_wdata[B_FLAG_IN])) |=> q.warn_raw);

    // R8: reset flag is sticky until explicitly cleared
    p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rst_raw && !(wr_ok && bus_addr == A_CLEAR && bus_wdata[B_FLAG_RS])) |=> q.rst_raw);
endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    logic [CNT_W-1:0] load_val, thr_val, snap_val;
    logic ld_req, cnt_en, snap_ack;
    logic ld_ack, warn_evt, rst_evt, snap_tgl;
    logic [3:0] to_bus_s;
    logic [2:0] to_slow_s;

    kwd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ld_ack_s(to_bus_s[0]), .warn_s(to_bus_s[1]), .rst_s(to_bus_s[2]),
        .snap_tgl_s(to_bus_s[3]), .snap_val(snap_val),
        .load_val(load_val), .thr_val(thr_val), .ld_req(ld_req),
        .cnt_en(cnt_en), .snap_ack(snap_ack), .irq(irq), .rst_req(rst_req)
    );

    kwd_sync #(.WIDTH(4)) u_sync_bus (
        .clk(clk), .rst_n(rst_n),
        .async_in({snap_tgl, rst_evt, warn_evt, ld_ack}),
        .sync_out(to_bus_s)
    );

    kwd_sync #(.WIDTH(3)) u_sync_slow (
        .clk(slow_clk), .rst_n(rst_n),
        .async_in({snap_ack, cnt_en, ld_req}),
        .sync_out(to_slow_s)
    );

    kwd_count #(.CNT_W(CNT_W)) u_count (
        .slow_clk(slow_clk), .rst_n(rst_n),
        .req_s(to_slow_s[0]), .en_s(to_slow_s[1]), .snap_ack_s(to_slow_s[2]),
        .load_in(load_val), .thr_in(thr_val),
        .ld_ack(ld_ack), .warn_evt(warn_evt), .rst_evt(rst_evt),
        .snap_tgl(snap_tgl), .snap_val(snap_val)
    );
endmodule

// File: tb/kwd_top_bench.sv
module kwd_top_bench;
    logic        clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;

    localparam logic [5:0] LLO = 6'h00, LHI = 6'h04, CTL = 6'h08, CLR = 6'h0C,
                           RAW = 6'h10, MSK = 6'h14, CLO = 6'h18, CHI = 6'h1C,
                           LCK = 6'h20, TLO = 6'h2C, THI = 6'h30;

    kwd_top u_kwd_top (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    always #10 clk = ~clk;
    initial begin
        #7;
        forever #100 slow_clk = ~slow_clk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = bus_rdata;
    endtask

    task automatic slow_wait(input int n);
        repeat (n) @(posedge slow_clk);
        @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int k;
        for (k = 0; k < 1000; k++) begin
            rd(RAW, v);
            if (!v[4]) break;
        end
        check(req, {31'b0, v[4]}, 32'd0);
    endtask

    task automatic read_count(output logic [31:0] c);
        logic [31:0] lo, hi;
        rd(CLO, lo);
        rd(CHI, hi);
        c = {hi[15:0], lo[15:0]};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, c;
        logic [31:0] pats [6];
        pats[0] = 32'h1234_5678; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0001_0000;
        pats[3] = 32'h0000_FFFF; pats[4] = 32'hA5A5_5A5A; pats[5] = 32'h8000_0001;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(LCK, v); check("R1 reset locked", v, 32'd0);
        rd(CTL, v); check("R4 reset ctrl", v, 32'd0);
        rd(RAW, v); check("R7 reset raw", v, 32'd0);
        check("R9 reset irq", {31'b0, irq}, 32'd0);
        check("R10 reset rst_req", {31'b0, rst_req}, 32'd0);

        // R2: locked writes ignored
        wr(CTL, 32'hF);
        rd(CTL, v); check("R2 locked ctrl write", v, 32'd0);
        wr(LLO, 32'h55);
        rd(LLO, v); check("R2 locked load write", v, 32'd0);
        rd(RAW, v); check("R2 locked load no busy", v, 32'd0);

        // R1: key handling
        wr(LCK, 32'h0000_E552);
        rd(LCK, v); check("R1 wrong key stays locked", v, 32'd0);
        wr(LCK, 32'h0001_E551);
        rd(LCK, v); check("R1 upper bits must match", v, 32'd0);
        wr(LCK, 32'h0000_E551);
        rd(LCK, v); check("R1 key unlocks", v, 32'd1);
        wr(LCK, 32'h0000_1234);
        rd(LCK, v); check("R1 other value relocks", v, 32'd0);
        wr(LCK, 32'h0000_E551);

        // R3/R11/R6: split registers and stopped count readback
        for (int i = 0; i < 6; i++) begin
            wr(LHI, {16'hDEAD, pats[i][31:16]});
            wr(THI, {16'hBEEF, ~pats[i][31:16]});
            wr(TLO, {16'hF00D, ~pats[i][15:0]});
            wr(LLO, {16'hCAFE, pats[i][15:0]});
            wait_idle("R5 transfer ends");
            rd(LLO, v); check("R3 load low", v, {16'h0, pats[i][15:0]});
            rd(LHI, v); check("R3 load high", v, {16'h0, pats[i][31:16]});
            rd(TLO, v); check("R3 threshold low", v, {16'h0, ~pats[i][15:0]});
            rd(THI, v); check("R3 threshold high", v, {16'h0, ~pats[i][31:16]});
            slow_wait(12);
            read_count(c); check("R11 R6 stopped count", c, pats[i]);
        end

        // R5: busy and frozen load registers
        wr(LHI, 32'h0);
        wr(LLO, 32'h100);
        rd(RAW, v); check("R5 busy after load", {31'b0, v[4]}, 32'd1);
        wr(LLO, 32'h200);
        wr(LHI, 32'h5);
        wr(TLO, 32'h7);
        wait_idle("R5 busy clears");
        rd(LLO, v); check("R5 low ignored while busy", v, 32'h100);
        rd(LHI, v); check("R5 high ignored while busy", v, 32'h0);
        rd(TLO, v); check("R5 threshold ignored while busy", v, {16'h0, ~pats[5][15:0]});
        slow_wait(12);
        read_count(c); check("R5 count got first value", c, 32'h100);

        // R4: control sweep
        for (int i = 0; i < 16; i++) begin
            wr(CTL, i);
            rd(CTL, v); check("R4 ctrl readback", v, i);
        end
        wr(CTL, 32'h0);

        // R6 R7 R8: run down with keep-alive
        wr(MSK, 32'h0);
        wr(THI, 32'h0); wr(TLO, 32'd12);
        wr(LHI, 32'h0); wr(LLO, 32'd40);
        wait_idle("R5 run load");
        wr(CTL, 32'hB);
        for (int k = 0; k < 3000; k++) begin
            rd(RAW, v);
            if (v[0]) break;
        end
        check("R7 warning raised", {31'b0, v[0]}, 32'd1);
        check("R8 no reset yet", {31'b0, v[3]}, 32'd0);
        check("R9 irq on warning", {31'b0, irq}, 32'd1);
        check("R10 no rst_req yet", {31'b0, rst_req}, 32'd0);
        read_count(c);
        check("R7 count near threshold", {31'b0, (c <= 32'd16 && c >= 32'd6)}, 32'd1);
        wr(LLO, 32'd40);
        wait_idle("R6 keep-alive transfer");
        slow_wait(5);
        read_count(c);
        check("R6 keep-alive reloaded", {31'b0, (c > 32'd20 && c <= 32'd40)}, 32'd1);
        rd(RAW, v); check("R7 sticky until cleared", {31'b0, v[0]}, 32'd1);
        wr(CLR, 32'h1);
        rd(RAW, v); check("R7 cleared", {31'b0, v[0]}, 32'd0);
        check("R9 irq drops on clear", {31'b0, irq}, 32'd0);
        for (int k = 0; k < 5000; k++) begin
            rd(RAW, v);
            if (v[3]) break;
        end
        check("R8 reset raised", {31'b0, v[3]}, 32'd1);
        check("R7 warning re-armed after clear", {31'b0, v[0]}, 32'd1);
        check("R10 rst_req on timeout", {31'b0, rst_req}, 32'd1);
        slow_wait(10);
        read_count(c); check("R6 no wrap at zero", c, 32'd0);
        slow_wait(10);
        read_count(c); check("R6 zero held", c, 32'd0);

        // R9: enable/mask gate
        for (int cb = 0; cb < 2; cb++) begin
            for (int m = 0; m < 2; m++) begin
                wr(CTL, 32'hA | cb);
                wr(MSK, m);
                check("R9 irq gate", {31'b0, irq}, (cb == 1 && m == 0) ? 32'd1 : 32'd0);
            end
        end
        wr(MSK, 32'h0);

        // R10: reset enable gate
        wr(CTL, 32'h3);
        check("R10 rst_req gated off", {31'b0, rst_req}, 32'd0);
        wr(CTL, 32'hB);
        check("R10 rst_req gated on", {31'b0, rst_req}, 32'd1);

        // R8 R7: independent clears
        wr(CLR, 32'h8);
        rd(RAW, v); check("R8 reset flag cleared", {31'b0, v[3]}, 32'd0);
        check("R8 warning untouched by reset clear", {31'b0, v[0]}, 32'd1);
        check("R10 rst_req after clear", {31'b0, rst_req}, 32'd0);
        wr(CLR, 32'h1);
        slow_wait(10);
        rd(RAW, v); check("R7 R8 no new event at zero", v, 32'd0);

        // R2: locked clear has no effect (flag set via fresh run)
        wr(TLO, 32'd3);
        wr(LLO, 32'd6);
        wait_idle("R5 short run load");
        for (int k = 0; k < 2000; k++) begin
            rd(RAW, v);
            if (v[3]) break;
        end
        wr(LCK, 32'h0);
        wr(CLR, 32'h9);
        rd(RAW, v); check("R2 locked clear ignored", v, 32'h9);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule